// File: doc/BRIEF.md
# Vector Length Setup Unit

This unit carries out two vector-management operations against a 64-bit vector state word that it keeps internally. The set-length operation picks a new maximum length and a new current length. The current length can come from an immediate, from a general-purpose register operand or from the count register. Register-sourced lengths saturate at 127, and the result is then clamped to the maximum length. Either limit raises an overflow flag. The operation can also reload the vertical-first mode bit and clear the remap persistence bit. The sub-vector status operation stores two reorder flags (pack and unpack) taken from the immediate and returns them as a result.

A decoder presents the decoded fields, the register operand and the count register value together with a one-cycle valid strobe. One clock edge later the unit commits the state word and registers its results: a GPR write (enable and data), an overflow flag, an optional CR0 field and a flag for reserved length or step values. The illegal-instruction trap itself belongs to the surrounding pipeline.

The state word uses MSB-first numbering: word bit 0 is vector bit [63]. The maximum length sits in word bits 0:6 (vector [63:57]). The current length sits in word bits 7:13 ([56:50]). The source step is in 14:20 ([49:43]) and the destination step in 21:27 ([42:36]). Pack is bit 53 ([10]), unpack is bit 54 ([9]), persistence is bit 62 ([1]) and vertical-first is bit 63 ([0]).

Top module: `vlsetup_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the whole state word and every registered output are cleared to zero.
- R2: In a set-length request (`op_sel`=0), the maximum length becomes `imm`+1 modulo 128 when `ms`=1. When `ms`=0 it keeps its current value.
- R3: With `vs`=1 and `ra_idx` nonzero, the length is taken from `ra_val`. If `ra_val` is above 127, the length becomes 127 and `ovf` is set. Otherwise the length is `ra_val[6:0]`.
- R4: With `vs`=1 and `ra_idx`=0, the length is taken from two sources. If `rt_idx`=0, it is `imm`+1 modulo 128. Otherwise it is taken from `ctr_val`, which saturates at 127 with `ovf` set in the same way as R3.
- R5: With `vs`=0, the current length keeps its present value before the clamp of R6 is applied.
- R6: If the selected length exceeds the new maximum length, the length is set to the maximum length and `ovf` is set. Both lengths are written into the state word.
- R7: A set-length request with nonzero `rt_idx` pulses `gpr_we` with `gpr_wdata` equal to the final length, zero-extended. With `rt_idx`=0 it does not pulse `gpr_we`. Whenever `gpr_we` is low, `gpr_wdata` is zero.
- R8: When `vs` or `ms` is 1, the vertical-first bit (word bit 63, [0]) takes `vf` and the persistence bit (word bit 62, [1]) is cleared. When both are 0, neither bit changes.
- R9: A status request (`op_sel`=1) whose immediate has `imm[3]` and `imm[2]` both set stores `imm[1]` into pack and `imm[0]` into unpack. It also pulses `gpr_we` with data {62 zeros, pack, unpack}, whatever the value of `rt_idx`.
- R10: A status request with `imm[3:2]` not equal to 2'b11 leaves the state word unchanged. It raises no output pulse.
- R11: For an effective request, `illegal` is set when the resulting maximum or current length exceeds 64, or when either step field is 64 or more.
- R12: With `rc`=1, an effective request pulses `cr0_we` with `cr0` = {LT=0, GT=0, EQ, SO} (MSB first). EQ is set when the written result is zero and SO copies `ovf`. With `rc`=0 there is no `cr0_we` pulse and `cr0` is zero.
- R13: Results appear on the outputs right after the clock edge that samples `req_valid`. In a cycle without a request the state word holds, and `gpr_we`, `cr0_we`, `ovf` and `illegal` return to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| op_sel | input | 1 | 0 = set length, 1 = sub-vector status |
| rt_idx | input | 5 | Target register index |
| ra_idx | input | 5 | Source register index |
| imm | input | 7 | Immediate (bit [6] is the MSB) |
| ms | input | 1 | Load maximum length |
| vs | input | 1 | Load current length |
| vf | input | 1 | Requested vertical-first mode |
| rc | input | 1 | Record CR0 |
| ra_val | input | 64 | Source register operand |
| ctr_val | input | 64 | Count register value |
| gpr_we | output | 1 | GPR write enable pulse |
| gpr_wdata | output | 64 | GPR write data |
| state_q | output | 64 | Current vector state word |
| ovf | output | 1 | Length saturated or clamped |
| cr0_we | output | 1 | CR0 write enable pulse |
| cr0 | output | 4 | {LT, GT, EQ, SO} |
| illegal | output | 1 | Reserved length or step value |

## Verification
Every result of this unit is due exactly one clock edge after the strobe that carries the request: the state word, the GPR pulse, the overflow flag, CR0 and the reserved flag. Nothing lingers into the following idle cycle. The bench drives each request on a falling edge. Its reference model steps at each rising edge, and every output is compared at the next falling edge, on every cycle, including idle cycles and cycles in reset. Each comparison carries the requirement tag of the request that was committed at that edge, so a result that is late, early or left stretched shows up as a mismatch tagged with its requirement.

// File: rtl/vlsetup_pkg.sv
package vlsetup_pkg;
  localparam int XLEN     = 64;
  localparam int LEN_W    = 7;
  localparam int IDX_W    = 5;
  localparam int RSV_MAX  = 64;

  // Field placement inside the state word (vector index, LSB of field)
  localparam int MVL_LSB     = 57;
  localparam int VL_LSB      = 50;
  localparam int SRC_LSB     = 43;
  localparam int DST_LSB     = 36;
  localparam int PACK_BIT    = 10;
  localparam int UNPACK_BIT  = 9;
  localparam int PERSIST_BIT = 1;
  localparam int VFIRST_BIT  = 0;

  typedef enum logic {
    OP_SETLEN = 1'b0,
    OP_STATUS = 1'b1
  } vls_op_e;
endpackage

// File: rtl/vls_sat.sv
module vls_sat #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic [XLEN-1:0]  src,
  output logic [LEN_W-1:0] len,
  output logic             sat
);
  assign sat = |src[XLEN-1:LEN_W];
  assign len = sat ? {LEN_W{1'b1}} : src[LEN_W-1:0];
endmodule

// File: rtl/vls_len_select.sv
module vls_len_select #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int IDX_W = 5
) (
  input  logic [LEN_W-1:0] imm,
  input  logic [LEN_W-1:0] cur_mvl,
  input  logic [LEN_W-1:0] cur_vl,
  input  logic             ms,
  input  logic             vs,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  output logic [LEN_W-1:0] new_mvl,
  output logic [LEN_W-1:0] new_vl,
  output logic             ovf
);
  localparam int N_SRC = 2;  // 0: register operand, 1: count register

  logic [XLEN-1:0]  src_val [N_SRC];
  logic [LEN_W-1:0] src_len [N_SRC];
  logic [N_SRC-1:0] src_sat;
  logic [LEN_W-1:0] imm_p1;
  logic [LEN_W-1:0] pick_vl;
  logic             pick_ovf;

  assign src_val[0] = ra_val;
  assign src_val[1] = ctr_val;

  for (genvar g = 0; g < N_SRC; g++) begin : g_sat
    vls_sat #(.XLEN(XLEN), .LEN_W(LEN_W)) u_sat (
      .src (src_val[g]),
      .len (src_len[g]),
      .sat (src_sat[g])
    );
  end

  assign imm_p1  = imm + 1'b1;
  assign new_mvl = ms ? imm_p1 : cur_mvl;

  always_comb begin
    pick_vl  = cur_vl;
    pick_ovf = 1'b0;
    if (vs) begin
      if (ra_idx != '0) begin
        pick_vl  = src_len[0];
        pick_ovf = src_sat[0];
      end else if (rt_idx == '0) begin
        pick_vl  = imm_p1;
      end else begin
        pick_vl  = src_len[1];
        pick_ovf = src_sat[1];
      end
    end
  end

  always_comb begin
    if (pick_vl > new_mvl) begin
      new_vl = new_mvl;
      ovf    = 1'b1;
    end else begin
      new_vl = pick_vl;
      ovf    = pick_ovf;
    end
  end
endmodule

// File: rtl/vls_stat_step.sv
module vls_stat_step #(
  parameter int LEN_W = 7
) (
  input  logic [LEN_W-1:0] imm,
  input  logic             cur_pack,
  input  logic             cur_unpack,
  output logic             hit,
  output logic             new_pack,
  output logic             new_unpack
);
  assign hit        = imm[3] & imm[2];
  assign new_pack   = hit ? imm[1] : cur_pack;
  assign new_unpack = hit ? imm[0] : cur_unpack;
endmodule

// File: rtl/vls_rsv_chk.sv
module vls_rsv_chk
  import vlsetup_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int LEN_W   = 7,
  parameter int RSV_LIM = 64
) (
  input  logic [XLEN-1:0] word,
  output logic            rsv
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(RSV_LIM);

  logic len_bad, step_bad;

  assign len_bad  = (word[MVL_LSB +: LEN_W] > LIM) || (word[VL_LSB +: LEN_W] > LIM);
  assign step_bad = (word[SRC_LSB +: LEN_W] >= LIM) || (word[DST_LSB +: LEN_W] >= LIM);
  assign rsv      = len_bad | step_bad;
endmodule

// File: rtl/vlsetup_unit.sv
module vlsetup_unit
  import vlsetup_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_LEN_W = LEN_W,
  parameter int P_IDX_W = IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               op_sel,
  input  logic [P_IDX_W-1:0] rt_idx,
  input  logic [P_IDX_W-1:0] ra_idx,
  input  logic [P_LEN_W-1:0] imm,
  input  logic               ms,
  input  logic               vs,
  input  logic               vf,
  input  logic               rc,
  input  logic [P_XLEN-1:0]  ra_val,
  input  logic [P_XLEN-1:0]  ctr_val,
  output logic               gpr_we,
  output logic [P_XLEN-1:0]  gpr_wdata,
  output logic [P_XLEN-1:0]  state_q,
  output logic               ovf,
  output logic               cr0_we,
  output logic [3:0]         cr0,
  output logic               illegal
);
  vls_op_e          op;
  logic [P_LEN_W-1:0] ls_mvl, ls_vl;
  logic             ls_ovf;
  logic             st_hit, st_pack, st_unpack;
  logic [P_XLEN-1:0] nxt_state;
  logic [P_XLEN-1:0] res_val;
  logic             res_we, res_ovf, act, nxt_rsv;

  assign op = vls_op_e'(op_sel);

  vls_len_select #(.XLEN(P_XLEN), .LEN_W(P_LEN_W), .IDX_W(P_IDX_W)) u_len (
    .imm     (imm),
    .cur_mvl (state_q[MVL_LSB +: P_LEN_W]),
    .cur_vl  (state_q[VL_LSB +: P_LEN_W]),
    .ms      (ms),
    .vs      (vs),
    .rt_idx  (rt_idx),
    .ra_idx  (ra_idx),
    .ra_val  (ra_val),
    .ctr_val (ctr_val),
    .new_mvl (ls_mvl),
    .new_vl  (ls_vl),
    .ovf     (ls_ovf)
  );

  vls_stat_step #(.LEN_W(P_LEN_W)) u_stat (
    .imm        (imm),
    .cur_pack   (state_q[PACK_BIT]),
    .cur_unpack (state_q[UNPACK_BIT]),
    .hit        (st_hit),
    .new_pack   (st_pack),
    .new_unpack (st_unpack)
  );

  vls_rsv_chk #(.XLEN(P_XLEN), .LEN_W(P_LEN_W), .RSV_LIM(RSV_MAX)) u_rsv (
    .word (nxt_state),
    .rsv  (nxt_rsv)
  );

  always_comb begin
    nxt_state = state_q;
    res_val   = '0;
    res_we    = 1'b0;
    res_ovf   = 1'b0;
    act       = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_SETLEN: begin
          act                          = 1'b1;
          nxt_state[MVL_LSB +: P_LEN_W] = ls_mvl;
          nxt_state[VL_LSB +: P_LEN_W]  = ls_vl;
          if (vs | ms) begin
            nxt_state[VFIRST_BIT]  = vf;
            nxt_state[PERSIST_BIT] = 1'b0;
          end
          res_ovf = ls_ovf;
          res_val = {{(P_XLEN-P_LEN_W){1'b0}}, ls_vl};
          res_we  = (rt_idx != '0);
        end
        OP_STATUS: begin
          if (st_hit) begin
            act                    = 1'b1;
            nxt_state[PACK_BIT]    = st_pack;
            nxt_state[UNPACK_BIT]  = st_unpack;
            res_val                = {{(P_XLEN-2){1'b0}}, st_pack, st_unpack};
            res_we                 = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= '0;
      gpr_we    <= 1'b0;
      gpr_wdata <= '0;
      ovf       <= 1'b0;
      cr0_we    <= 1'b0;
      cr0       <= '0;
      illegal   <= 1'b0;
    end else begin
      state_q   <= nxt_state;
      gpr_we    <= res_we;
      gpr_wdata <= res_we ? res_val : '0;
      ovf       <= res_ovf;
      cr0_we    <= act & rc;
      cr0       <= (act & rc) ? {2'b00, (res_val == '0), res_ovf} : 4'b0000;
      illegal   <= act & nxt_rsv;
    end
  end
endmodule

// File: rtl/vlsetup_unit_chk.sv
module vlsetup_unit_chk
  import vlsetup_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_LEN_W = LEN_W,
  parameter int P_IDX_W = IDX_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               op_sel,
  input logic [P_IDX_W-1:0] ra_idx,
  input logic               ms,
  input logic               vs,
  input logic               rc,
  input logic [P_XLEN-1:0]  ra_val,
  input logic               gpr_we,
  input logic [P_XLEN-1:0]  gpr_wdata,
  input logic [P_XLEN-1:0]  state_q,
  input logic               ovf,
  input logic               cr0_we,
  input logic [3:0]         cr0,
  input logic               illegal
);
  a_r3_ra_saturates: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_sel && vs && ra_idx != '0 && ra_val[P_XLEN-1:P_LEN_W] != '0) |=> ovf);

  a_r6_vl_within_mvl: assert property (@(posedge clk) disable iff (rst)
    state_q[VL_LSB +: P_LEN_W] <= state_q[MVL_LSB +: P_LEN_W]);

  a_r7_zero_extended: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> (gpr_wdata[P_XLEN-1:P_LEN_W] == '0));

  a_r8_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_sel && !vs && !ms) |=>
      (state_q[PERSIST_BIT] == $past(state_q[PERSIST_BIT]) &&
       state_q[VFIRST_BIT] == $past(state_q[VFIRST_BIT])));

  a_r12_cr0_shape: assert property (@(posedge clk) disable iff (rst)
    cr0_we |-> (cr0[3:2] == 2'b00 && cr0[0] == ovf));

  a_r12_no_record: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rc) |=> !cr0_we);

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!gpr_we && !cr0_we && !ovf && !illegal && state_q == $past(state_q)));
endmodule

bind vlsetup_unit vlsetup_unit_chk #(
  .P_XLEN (P_XLEN),
  .P_LEN_W(P_LEN_W),
  .P_IDX_W(P_IDX_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .op_sel    (op_sel),
  .ra_idx    (ra_idx),
  .ms        (ms),
  .vs        (vs),
  .rc        (rc),
  .ra_val    (ra_val),
  .gpr_we    (gpr_we),
  .gpr_wdata (gpr_wdata),
  .state_q   (state_q),
  .ovf       (ovf),
  .cr0_we    (cr0_we),
  .cr0       (cr0),
  .illegal   (illegal)
);

// File: tb/test_vlsetup_unit.sv
`timescale 1ns/1ps
module test_vlsetup_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        op_sel = 1'b0;
  logic [4:0]  rt_idx = '0;
  logic [4:0]  ra_idx = '0;
  logic [6:0]  imm = '0;
  logic        ms = 1'b0, vs = 1'b0, vf = 1'b0, rc = 1'b0;
  logic [63:0] ra_val = '0, ctr_val = '0;

  logic        gpr_we, ovf, cr0_we, illegal;
  logic [63:0] gpr_wdata, state_q;
  logic [3:0]  cr0;

  vlsetup_unit i_vlsetup_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_sel(op_sel),
    .rt_idx(rt_idx), .ra_idx(ra_idx), .imm(imm), .ms(ms), .vs(vs), .vf(vf),
    .rc(rc), .ra_val(ra_val), .ctr_val(ctr_val), .gpr_we(gpr_we),
    .gpr_wdata(gpr_wdata), .state_q(state_q), .ovf(ovf), .cr0_we(cr0_we),
    .cr0(cr0), .illegal(illegal)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    seen     = 1'b0;
  bit    finished = 1'b0;
  string cur_tag  = "R1";

  // reference model state
  logic [6:0] m_mvl = '0, m_vl = '0;
  logic       m_pack = 1'b0, m_unpack = 1'b0, m_persist = 1'b0, m_vf = 1'b0;
  // expected outputs
  logic        e_we = 1'b0, e_ov = 1'b0, e_cwe = 1'b0, e_ill = 1'b0;
  logic [63:0] e_wd = '0;
  logic [3:0]  e_cr0 = '0;
  string       e_tag = "R1";

  always @(posedge clk) begin : model
    int  nm, nv, ip1;
    bit  ov, act;
    logic [63:0] res;
    act = 1'b0; ov = 1'b0; res = '0;
    e_we = 1'b0; e_wd = '0; e_ov = 1'b0; e_cwe = 1'b0; e_cr0 = '0; e_ill = 1'b0;
    if (rst) begin
      m_mvl = '0; m_vl = '0; m_pack = 0; m_unpack = 0; m_persist = 0; m_vf = 0;
      e_tag = "R1";
    end else if (!req_valid) begin
      e_tag = "R13";
    end else begin
      e_tag = cur_tag;
      ip1 = (int'(imm) + 1) % 128;
      if (op_sel == 1'b0) begin
        act = 1'b1;
        nm = ms ? ip1 : int'(m_mvl);
        if (!vs) nv = int'(m_vl);
        else if (ra_idx != 0) begin
          if (ra_val > 64'd127) begin nv = 127; ov = 1'b1; end
          else nv = int'(ra_val % 128);
        end else if (rt_idx == 0) nv = ip1;
        else begin
          if (ctr_val > 64'd127) begin nv = 127; ov = 1'b1; end
          else nv = int'(ctr_val % 128);
        end
        if (nv > nm) begin nv = nm; ov = 1'b1; end
        m_mvl = 7'(nm); m_vl = 7'(nv);
        if (vs || ms) begin m_vf = vf; m_persist = 1'b0; end
        res = 64'(nv);
        e_we = (rt_idx != 0);
        e_wd = e_we ? res : '0;
      end else if (imm[3] && imm[2]) begin
        act = 1'b1;
        m_pack = imm[1]; m_unpack = imm[0];
        res = 64'(2 * int'(m_pack) + int'(m_unpack));
        e_we = 1'b1; e_wd = res;
      end
      if (act) begin
        e_ov  = ov;
        e_ill = (m_mvl > 7'd64) || (m_vl > 7'd64);
        if (rc) begin e_cwe = 1'b1; e_cr0 = {2'b00, res == 0, ov}; end
      end
    end
    seen = 1'b1;
  end

  task automatic chk(input string what, input logic [63:0] act_v, input logic [63:0] exp_v);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", e_tag, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (seen && !finished) begin
      chk("state", state_q,
          {m_mvl, m_vl, 39'd0, m_pack, m_unpack, 7'd0, m_persist, m_vf});
      chk("gpr_we", 64'(gpr_we), 64'(e_we));
      chk("gpr_wdata", gpr_wdata, e_wd);
      chk("ovf", 64'(ovf), 64'(e_ov));
      chk("cr0_we", 64'(cr0_we), 64'(e_cwe));
      chk("cr0", 64'(cr0), 64'(e_cr0));
      chk("illegal", 64'(illegal), 64'(e_ill));
    end
  end

  task automatic req(input string t, input logic o, input logic [4:0] rt, input logic [4:0] ra,
                     input logic [6:0] im, input logic m, input logic v, input logic f,
                     input logic r, input logic [63:0] rav, input logic [63:0] ctv);
    @(negedge clk);
    cur_tag = t;
    op_sel = o; rt_idx = rt; ra_idx = ra; imm = im; ms = m; vs = v; vf = f; rc = r;
    ra_val = rav; ctr_val = ctv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ra_val = 64'hDEAD_BEEF_0000_0001; ctr_val = '1; imm = 7'h7F;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R2 R4: MVL from immediate, VL from immediate, no GPR write
    req("R2", 0, 5'd0, 5'd0, 7'd15, 1, 1, 1, 0, 64'd0, 64'd0);
    // R3 R7: VL from register operand, written to GPR
    req("R3", 0, 5'd5, 5'd3, 7'd0, 0, 1, 0, 1, 64'd10, 64'd0);
    // R3 R11: register saturates at 127, MVL 127 is reserved
    req("R3", 0, 5'd5, 5'd3, 7'd126, 1, 1, 1, 1, 64'd1000, 64'd0);
    // R6: clamp to MVL 8
    req("R6", 0, 5'd7, 5'd1, 7'd7, 1, 1, 0, 1, 64'd20, 64'd0);
    // R4: count register source
    req("R4", 0, 5'd4, 5'd0, 7'd0, 0, 1, 1, 1, 64'd0, 64'd5);
    // R4: count register saturates then clamps
    req("R4", 0, 5'd4, 5'd0, 7'd0, 0, 1, 0, 1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5 R8: nothing loaded, mode bits held
    req("R8", 0, 5'd2, 5'd0, 7'd30, 0, 0, 1, 1, 64'd99, 64'd99);
    // R5 R6: VL kept but clamped to new MVL 3
    req("R5", 0, 5'd2, 5'd0, 7'd2, 1, 0, 1, 1, 64'd0, 64'd0);
    // R12: zero length sets EQ
    req("R12", 0, 5'd1, 5'd6, 7'd0, 0, 1, 0, 1, 64'd0, 64'd0);
    // R9: status step stores pack=1 unpack=0
    req("R9", 1, 5'd0, 5'd0, 7'b1001110, 0, 0, 0, 1, 64'd0, 64'd0);
    // R10: status immediate without both select bits
    req("R10", 1, 5'd3, 5'd0, 7'b0000111, 0, 0, 0, 1, 64'd0, 64'd0);
    // R9 R12: both flags cleared, result zero
    req("R9", 1, 5'd3, 5'd0, 7'b0001100, 1, 1, 1, 1, 64'd0, 64'd0);
    // R9: unpack only
    req("R9", 1, 5'd0, 5'd0, 7'b0001101, 0, 0, 0, 0, 64'd0, 64'd0);
    // R2: immediate 127 wraps to MVL 0, VL clamped to 0
    req("R2", 0, 5'd9, 5'd2, 7'd127, 1, 1, 0, 1, 64'd40, 64'd0);
    // R11: MVL 65 and VL 65 reserved
    req("R11", 0, 5'd0, 5'd0, 7'd64, 1, 1, 1, 1, 64'd0, 64'd0);
    // R11: MVL 64 and VL 64 legal
    req("R11", 0, 5'd0, 5'd0, 7'd63, 1, 1, 0, 0, 64'd0, 64'd0);
    // R12: rc=0 keeps CR0 quiet
    req("R12", 0, 5'd8, 5'd8, 7'd0, 0, 1, 1, 0, 64'd12, 64'd0);
    // R1: reset in the middle clears state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    req("R7", 0, 5'd0, 5'd4, 7'd0, 0, 1, 0, 1, 64'd0, 64'd0);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end
endmodule